// File: doc/BRIEF.md
# Interrupt Capture and Replay Logger

This block sits on the interrupt request lines between a set of sources and the CPU's interrupt-flag register while a self-test runs. When the log enable is raised, one clock later the block stops forwarding requests to the CPU. It records each arriving request in a sticky pending bit instead. When the self-test engine strobes test-done, every pending request is issued to the CPU on the next cycle as a one-cycle pulse, and the pending vector is cleared.

Some sources hold a request for two clock cycles and others for one. Each line is therefore declared as wide or narrow through a parameter. A wide line is captured only on its rising edge. A wide request whose first cycle was forwarded just before logging took effect is not recorded a second time. This keeps the CPU from receiving a spurious repeat after replay.

When logging is inactive the block is fully transparent, with no added latency. The pending vector can be observed at any time.

Top module: `irq_replay_logger`

## Requirements
- R1: During and right after reset the pending vector `logged` is all zero, logging is inactive and `irq_out` equals `irq_in`.
- R2: While logging is inactive and no replay is in progress, `irq_out` equals `irq_in` in the same cycle (zero latency).
- R3: Logging takes effect one cycle after `log_en` is first sampled high. A request present in the cycle where `log_en` first rises is forwarded to `irq_out`.
- R4: While logging is active, `irq_out` shows no request taken from `irq_in`. Only replay pulses can appear.
- R5: A line whose `WIDE_MASK` bit is 1 (two-cycle source) is recorded only on a rising edge during active logging. If it was already high in the previous cycle, it is not recorded.
- R6: A line whose `WIDE_MASK` bit is 0 (one-cycle source) is recorded in every active-logging cycle in which it is high.
- R7: A bit of `logged` stays set until a test-done strobe. No bit falls without one.
- R8: In the cycle after `test_done` is sampled high, `irq_out` carries every recorded request, and `logged` reads zero.
- R9: A request recorded in the test-done cycle itself is part of the replay. A request arriving in the replay cycle with logging inactive is forwarded in that same cycle, merged with the replay.
- R10: Each replay pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | Interrupt request lines from the sources |
| log_en | input | 1 | Logging request; takes effect one cycle later |
| test_done | input | 1 | One-cycle strobe: self-test finished, replay the pending requests |
| irq_out | output | N_IRQ | Gated interrupt lines toward the CPU flag register |
| logged | output | N_IRQ | Pending (recorded, not yet replayed) requests |

## Verification
The hardest situation to reach is the enable boundary. A two-cycle request has to straddle it: its first cycle comes in the cycle where `log_en` rises, and its second cycle comes in the first cycle of active logging. The bench drives all four lines high across exactly those two cycles. It then checks that only the narrow lines appear in `logged` and in the replay, while the wide lines were forwarded once and never again. A second scenario raises a new request in the test-done cycle and another in the replay cycle, so that capture, replay and pass-through meet on the same edge.

// File: rtl/irqlog_boundary.sv
module irqlog_boundary #(
  parameter int N_IRQ = 8,
  parameter logic [N_IRQ-1:0] WIDE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             log_en,
  output logic             log_act,
  output logic [N_IRQ-1:0] cap
);
  logic [N_IRQ-1:0] irq_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      log_act  <= 1'b0;
      irq_prev <= '0;
    end else begin
      log_act  <= log_en;
      irq_prev <= irq_in;
    end
  end

  // Per-line capture: wide sources by edge, narrow sources by level
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    if (WIDE_MASK[i]) begin : g_wide
      assign cap[i] = log_act & irq_in[i] & ~irq_prev[i];
    end else begin : g_narrow
      assign cap[i] = log_act & irq_in[i];
    end
  end

  // R3: logging state follows the enable with one cycle of delay
  a_r3_enable_delay: assert property (@(posedge clk) disable iff (rst)
    log_en |=> log_act);
endmodule

// File: rtl/irqlog_store.sv
module irqlog_store #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] cap,
  input  logic             test_done,
  output logic [N_IRQ-1:0] pend,
  output logic [N_IRQ-1:0] replay
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      replay <= '0;
    end else if (test_done) begin
      replay <= pend | cap;
      pend   <= '0;
    end else begin
      replay <= '0;
      pend   <= pend | cap;
    end
  end

  // R7: pending bits only fall on a test-done strobe
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !test_done |=> ((pend & $past(pend)) == $past(pend)));

  // R8: pending vector empty after a strobe
  a_r8_cleared: assert property (@(posedge clk) disable iff (rst)
    test_done |=> (pend == '0));

  // R10: replay only in the cycle right after a strobe
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !test_done |=> (replay == '0));
endmodule

// File: rtl/irq_replay_logger.sv
module irq_replay_logger #(
  parameter int N_IRQ = 8,
  parameter logic [N_IRQ-1:0] WIDE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             log_en,
  input  logic             test_done,
  output logic [N_IRQ-1:0] irq_out,
  output logic [N_IRQ-1:0] logged
);
  logic             log_act;
  logic [N_IRQ-1:0] cap;
  logic [N_IRQ-1:0] replay;

  irqlog_boundary #(.N_IRQ(N_IRQ), .WIDE_MASK(WIDE_MASK)) u_bnd (
    .clk(clk), .rst(rst), .irq_in(irq_in), .log_en(log_en),
    .log_act(log_act), .cap(cap)
  );

  irqlog_store #(.N_IRQ(N_IRQ)) u_store (
    .clk(clk), .rst(rst), .cap(cap), .test_done(test_done),
    .pend(logged), .replay(replay)
  );

  assign irq_out = (log_act ? '0 : irq_in) | replay;

  // R2: transparent when logging was off and no strobe came last cycle
  a_r2_transparent: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(log_en) && !$past(test_done)) |-> (irq_out == irq_in));

  // R4: nothing forwarded while logging is active outside replay
  a_r4_blocked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(log_en) && !$past(test_done)) |-> (irq_out == '0));
endmodule

// File: tb/tb_irq_replay_logger.sv
module tb_irq_replay_logger;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] irq_in;
  logic log_en, test_done;
  logic [N-1:0] irq_out, logged;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // lines 3,2 are two-cycle sources; lines 1,0 are one-cycle sources
  irq_replay_logger #(.N_IRQ(N), .WIDE_MASK(4'b1100)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .log_en(log_en),
    .test_done(test_done), .irq_out(irq_out), .logged(logged)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  // drive one cycle: inputs after the edge, leave time to sample mid-cycle
  task automatic cyc(input logic [N-1:0] irq, input logic le, input logic td);
    @(posedge clk); #1;
    irq_in = irq; log_en = le; test_done = td;
    #4;
  endtask

  task automatic t_reset();
    rst = 1'b1; irq_in = 4'b0101; log_en = 1'b0; test_done = 1'b0;
    @(posedge clk); @(posedge clk); #5;
    chk("R1 logged in reset", logged, 4'b0000);
    chk("R1 passthrough in reset", irq_out, 4'b0101);
    @(posedge clk); #1; rst = 1'b0; irq_in = '0; #4;
    chk("R1 logged after reset", logged, 4'b0000);
  endtask

  task automatic t_transparent();
    cyc(4'b1010, 0, 0); chk("R2 pattern 1010", irq_out, 4'b1010);
    cyc(4'b0111, 0, 0); chk("R2 pattern 0111", irq_out, 4'b0111);
    cyc(4'b0000, 0, 0); chk("R2 pattern 0000", irq_out, 4'b0000);
  endtask

  task automatic t_boundary();
    cyc(4'b1111, 1, 0); chk("R3 forwarded on enable cycle", irq_out, 4'b1111);
    cyc(4'b1111, 1, 0); chk("R4 blocked while active", irq_out, 4'b0000);
    cyc(4'b0000, 1, 0);
    chk("R5 R6 straddle: only narrow lines recorded", logged, 4'b0011);
    cyc(4'b0000, 0, 1); chk("R4 no output in strobe cycle", irq_out, 4'b0000);
    cyc(4'b0000, 0, 0);
    chk("R8 replay of narrow lines", irq_out, 4'b0011);
    chk("R8 logged cleared", logged, 4'b0000);
    cyc(4'b0000, 0, 0); chk("R10 replay lasts one cycle", irq_out, 4'b0000);
  endtask

  task automatic t_capture_replay();
    cyc(4'b0000, 1, 0);
    cyc(4'b0100, 1, 0); chk("R4 wide request held back", irq_out, 4'b0000);
    cyc(4'b0100, 1, 0);
    cyc(4'b0001, 1, 0); chk("R5 wide edge recorded once", logged, 4'b0100);
    cyc(4'b0000, 1, 0); chk("R6 narrow pulse recorded", logged, 4'b0101);
    cyc(4'b0000, 1, 0); cyc(4'b0000, 1, 0);
    chk("R7 pending stays set", logged, 4'b0101);
    cyc(4'b1000, 0, 1);
    cyc(4'b0010, 0, 0);
    chk("R9 strobe-cycle capture plus replay-cycle forward", irq_out, 4'b1111);
    chk("R8 logged cleared after replay", logged, 4'b0000);
    cyc(4'b0000, 0, 0); chk("R10 no repeat after replay", irq_out, 4'b0000);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_transparent();
    t_boundary();
    t_capture_replay();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule